// File: doc/BRIEF.md
# Sub-Vector Pack/Unpack Index Sequencer

This block produces the stream of element offset pairs that drive a vector move over short sub-vectors. The move has a vector length (VL) of whole elements and a sub-vector length of one to four components. A source walker produces the read offsets and a destination walker produces the write offsets. Each walker can visit the components in one of two orders. In element-major order, all components of element 0 come first, then all of element 1, and so on. In component-major order, component 0 of every element comes first, then component 1, and so on. Both orders emit the offset `i*SUBVL + j` for element `i` and component `j`.

The source walker switches to component-major order when the pack bit is set. The destination walker switches to component-major order when the unpack bit is set. A move with pack set gathers each component into its own contiguous plane. A move with unpack set scatters planes back into interleaved sub-vectors. Both bits may be set at once.

A start pulse latches the parameters. One pair is then offered per beat on a valid/ready handshake, and the two walkers step together on every accepted beat. The final pair carries a last flag. One cycle later the block is idle and pulses done.

Top module: `subvec_index_seq`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `done` are low.
- R2: The sub-vector length is `subvl_m1 + 1`, and `vl` is 1 to 64. A started move offers exactly `vl*(subvl_m1+1)` beats. When a walker is in element-major order, its k-th offset is k.
- R3: In component-major order, a walker's outer loop runs over component `j` and its inner loop over element `i`. The k-th offset is `i*SUBVL + j`, where `j = k / vl` and `i = k % vl`.
- R4: The source walker uses component-major order exactly when `pack_en` was high at start. The destination walker does so exactly when `unpack_en` was high. When both are high, both walkers use component-major order and each pair has equal offsets.
- R5: When the sub-vector length is 1, the source and destination offsets are equal on every beat, whatever the mode bits.
- R6: `out_last` is high only with the final pair. The cycle after that pair is accepted, `done` is high for one cycle and `out_valid` is low.
- R7: A start with `vl` of 0 offers no beat, and `done` is high for one cycle on the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, the offsets and `out_last` keep their values, and `out_valid` stays high.
- R9: A start pulse that arrives while a move is in progress is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move; ignored while busy |
| vl | input | VLW | Number of elements, sampled at start |
| subvl_m1 | input | 2 | Sub-vector length minus one, sampled at start |
| pack_en | input | 1 | Source walker in component-major order |
| unpack_en | input | 1 | Destination walker in component-major order |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | A pair is offered |
| src_off | output | OFFW | Source element offset |
| dst_off | output | OFFW | Destination element offset |
| out_last | output | 1 | Final pair of the move |
| done | output | 1 | One-cycle pulse when the move has completed |

## Verification
The bench targets the inner-loop wrap in component-major order. There, a wrong outer step would restart the plane at the wrong component, or would run past the number of components. It runs the largest move, 64 elements of four components, to catch an offset register that is too narrow. It also runs the single-component case, where a mode bit that leaked into the stride would split the two walkers. Stalls, mid-run start pulses and a zero-length move expose, in turn: a walker that steps without acceptance, a restart that corrupts the running sequence, and a done that never arrives or comes with a spurious beat.

// File: rtl/subvec_index_seq.sv
module subvec_index_seq #(
  parameter int VLW  = 7,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [1:0]      subvl_m1,
  input  logic            pack_en,
  input  logic            unpack_en,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [OFFW-1:0] src_off,
  output logic [OFFW-1:0] dst_off,
  output logic            out_last,
  output logic            done
);
  localparam int LW = 3;

  logic           busy;
  logic [VLW-1:0] vl_q;
  logic [LW-1:0]  len_q;
  logic [1:0]     tr_q;

  wire start_ok = start & ~busy;
  wire accept   = busy & out_ready;

  wire [VLW-1:0]  len_v  = {{(VLW-LW){1'b0}}, len_q};
  wire [OFFW-1:0] len_o  = {{(OFFW-LW){1'b0}}, len_q};
  wire [VLW-1:0]  vl_lim = vl_q - 1'b1;
  wire [VLW-1:0]  ln_lim = len_v - 1'b1;

  for (genvar g = 0; g < 2; g++) begin : w
    logic [VLW-1:0]  inner, outer;
    logic [OFFW-1:0] base, off;
    wire             tr     = tr_q[g];
    wire [VLW-1:0]   ilim   = tr ? vl_lim : ln_lim;
    wire [VLW-1:0]   olim   = tr ? ln_lim : vl_lim;
    wire [OFFW-1:0]  istep  = tr ? len_o : {{(OFFW-1){1'b0}}, 1'b1};
    wire [OFFW-1:0]  ostep  = tr ? {{(OFFW-1){1'b0}}, 1'b1} : len_o;
    wire             i_end  = (inner == ilim);
    wire             at_end = i_end && (outer == olim);

    always_ff @(posedge clk) begin
      if (!rst_n || start_ok) begin
        inner <= '0;
        outer <= '0;
        base  <= '0;
        off   <= '0;
      end else if (accept) begin
        if (i_end) begin
          inner <= '0;
          outer <= outer + 1'b1;
          base  <= base + ostep;
          off   <= base + ostep;
        end else begin
          inner <= inner + 1'b1;
          off   <= off + istep;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      vl_q  <= '0;
      len_q <= '0;
      tr_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        vl_q  <= vl;
        len_q <= {1'b0, subvl_m1} + 1'b1;
        tr_q  <= {unpack_en, pack_en};
        busy  <= (vl != '0);
        done  <= (vl == '0);
      end else if (accept && w[0].at_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign out_valid = busy;
  assign out_last  = busy & w[0].at_end;
  assign src_off   = w[0].off;
  assign dst_off   = w[1].off;
endmodule

module subvec_index_seq_chk #(
  parameter int VLW  = 7,
  parameter int OFFW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VLW-1:0]  vl,
  input logic            busy,
  input logic [VLW-1:0]  vl_q,
  input logic [2:0]      len_q,
  input logic [1:0]      tr_q,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OFFW-1:0] src_off,
  input logic [OFFW-1:0] dst_off,
  input logic            out_last,
  input logic            done
);
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(src_off) && $stable(dst_off) && $stable(out_last));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done && !out_valid);

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r1_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vl == '0 |=> done && !out_valid);

  a_r5_unit_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && len_q == 3'd1 |-> src_off == dst_off);

  a_r4_both_same: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tr_q == 2'b11 |-> src_off == dst_off);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(src_off) < 32'(vl_q) * 32'(len_q)) && (32'(dst_off) < 32'(vl_q) * 32'(len_q)));
endmodule

bind subvec_index_seq subvec_index_seq_chk #(.VLW(VLW), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy), .vl_q(vl_q),
  .len_q(len_q), .tr_q(tr_q), .out_valid(out_valid), .out_ready(out_ready),
  .src_off(src_off), .dst_off(dst_off), .out_last(out_last), .done(done)
);

// File: tb/test_subvec_index_seq.sv
module test_subvec_index_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic [6:0] vl = '0;
  logic [1:0] subvl_m1 = '0;
  logic       pack_en = 0, unpack_en = 0, out_ready = 0;
  logic       out_valid, out_last, done;
  logic [7:0] src_off, dst_off;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subvec_index_seq i_subvec_index_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
    .pack_en(pack_en), .unpack_en(unpack_en), .out_ready(out_ready),
    .out_valid(out_valid), .src_off(src_off), .dst_off(dst_off),
    .out_last(out_last), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input bit tr, input int v, input int s, input int k);
    if (!tr) return k;
    return (k % v) * s + (k / v);
  endfunction

  function automatic bit rdy(input int pat, input int cyc);
    case (pat)
      1: return (cyc % 2) == 1;
      2: return (cyc % 3) != 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last && !done, "R1 reset", {out_valid, out_last, done}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_case(input int v, input int s, input bit pk, input bit up,
                          input int pat, input bit poke, input string tag);
    int k = 0;
    int cyc = 0;
    int n = v * s;
    bit held = 0;
    logic [7:0] hs = '0, hd = '0;
    vl = 7'(v); subvl_m1 = 2'(s - 1); pack_en = pk; unpack_en = up; start = 1;
    @(negedge clk);
    start = 0;
    while (k < n && cyc < 3000) begin
      out_ready = rdy(pat, cyc);
      if (poke && k == 2) begin
        start = 1; vl = 7'd9; pack_en = ~pk; subvl_m1 = 2'd0;
      end else start = 0;
      if (held) check(out_valid && src_off == hs && dst_off == hd, {tag, " R8 hold"}, src_off, hs);
      held = 0;
      check(out_valid && !done, {tag, " R2 valid during move"}, out_valid, 1);
      if (out_ready) begin
        check(src_off == 8'(exp_off(pk, v, s, k)), {tag, " R3/R4 src"}, src_off, exp_off(pk, v, s, k));
        check(dst_off == 8'(exp_off(up, v, s, k)), {tag, " R3/R4 dst"}, dst_off, exp_off(up, v, s, k));
        check(out_last == (k == n - 1), {tag, " R6 last"}, out_last, k == n - 1);
        k++;
      end else begin
        held = 1; hs = src_off; hd = dst_off;
      end
      cyc++;
      @(negedge clk);
    end
    start = 0;
    out_ready = 0;
    check(k == n, {tag, " R2 beat count"}, k, n);
    check(done && !out_valid, {tag, " R6 done pulse"}, {done, out_valid}, 2);
    @(negedge clk);
    check(!done && !out_valid, {tag, " R6 idle"}, {done, out_valid}, 0);
  endtask

  task automatic t_empty();
    vl = 7'd0; subvl_m1 = 2'd2; pack_en = 1; unpack_en = 0; start = 1; out_ready = 1;
    @(negedge clk);
    start = 0;
    check(done && !out_valid, "R7 empty done", {done, out_valid}, 2);
    @(negedge clk);
    check(!done && !out_valid, "R7 no beats", {done, out_valid}, 0);
    out_ready = 0;
  endtask

  initial begin
    t_reset();
    run_case(5, 3, 0, 0, 0, 0, "normal");
    run_case(4, 4, 1, 0, 0, 0, "pack");
    run_case(3, 2, 0, 1, 2, 0, "unpack-stall");
    run_case(6, 3, 1, 1, 1, 0, "both");
    run_case(7, 1, 1, 0, 0, 0, "R5 unit-pack");
    run_case(7, 1, 0, 1, 2, 0, "R5 unit-unpack");
    run_case(1, 1, 0, 0, 0, 0, "single");
    run_case(64, 4, 1, 0, 2, 0, "max-pack");
    run_case(5, 2, 0, 1, 1, 1, "R9 restart-ignored");
    t_empty();
    run_case(2, 4, 0, 1, 0, 0, "after-empty");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule